// File: doc/BRIEF.md
# Nine-Bit Serial Panel Interface

This block is a three-wire serial master for a display controller that frames every word as nine bits. The host starts either a write or an identification read with a one-cycle request. A write sends one command word and then a chosen number of parameter words. The parameter bytes stream in through a valid/ready port. The block drives an active-low chip select, a serial clock and a data-out line, and it samples a data-in line.

Every word goes out most-significant bit first. The first bit on the wire is a data/command flag: 0 marks a command and 1 marks a parameter. An identification read sends command 0x04. It then clocks nine bits that it discards, which gives one turnaround clock plus one dummy byte. It then clocks eight bits and keeps them as the panel identifier. The serial clock follows mode 0: it idles low, the panel samples data on the rising edge, and data changes on the falling edge. One serial clock period lasts 2*DIV system clocks.

The parameter port follows these back-pressure rules. `prm_ready` is high only while the block waits for the next parameter and the shifter is free. A byte is taken on a cycle where `prm_valid` and `prm_ready` are both high. The host may hold `prm_valid` low for any number of cycles, and the frame stretches to match with chip select still held low.

Top module: `panel9_serial_master`

## Requirements
- R1: Every write word is 9 bits long and is shifted most-significant bit first, so bit 8, the data/command flag, is the first bit clocked out.
- R2: The command word of a write is the 9-bit value {0, cmd_byte}.
- R3: After the command word come exactly param_cnt words {1, byte}, in the order the bytes were accepted. With param_cnt = 0 the frame holds only the command word.
- R4: The serial clock idles low. Data out holds steady while the serial clock is high. Consecutive rising edges in a frame are 2*DIV system clocks apart.
- R5: An identification read sends the word 0x004, then clocks 9 bits that are discarded, then 8 bits, which are captured MSB first into id_byte. The frame is 26 clocks long, and id_byte keeps its value until the next read completes.
- R6: cs_n is low from the cycle after a request is accepted until the last bit of the frame has been clocked. done is then high for exactly one cycle, and in that cycle cs_n returns high and busy falls.
- R7: req_ready is high only when the block is idle. wr_req and rd_req are ignored while the block is busy. If both are high in the same idle cycle, the write wins.
- R8: prm_ready is high only while a parameter is pending and the shifter is free. A byte is consumed only on a cycle where prm_valid and prm_ready are both high.
- R9: After reset, cs_n = 1, sclk = 0, sdo = 0, busy = 0, done = 0, req_ready = 1 and id_byte = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_req | input | 1 | Start a write (command plus parameters) |
| rd_req | input | 1 | Start an identification read |
| cmd_byte | input | 8 | Command byte for a write |
| param_cnt | input | PCW | Number of parameter bytes for a write |
| req_ready | output | 1 | Block idle, a request will be taken |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |
| prm_valid | input | 1 | Parameter byte valid |
| prm_data | input | 8 | Parameter byte |
| prm_ready | output | 1 | Parameter byte will be taken this cycle |
| id_byte | output | 8 | Identifier from the last read |
| cs_n | output | 1 | Chip select, active low |
| sclk | output | 1 | Serial clock, mode 0 |
| sdo | output | 1 | Serial data to the panel |
| sdi | input | 1 | Serial data from the panel |

## Verification
The assertions assume that the host samples wr_req, rd_req, cmd_byte and param_cnt only in a cycle where req_ready is high. They also assume that prm_data is meaningful only together with prm_valid, and that param_cnt never exceeds MAX_PARAMS. The bench drives requests on the falling system clock edge as one-cycle pulses, and it uses counts that fit the parameter width. It stalls the parameter stream on some cycles to exercise back-pressure. It also raises requests during busy on purpose, to show that they are ignored. A simple panel model drives sdi high through every bit outside the identifier window, so a design that wrongly keeps the dummy bits gives a wrong identifier.

// File: rtl/p9_pkg.sv
package p9_pkg;
  localparam int WORD_W = 9;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] ID_CMD = 8'h04;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD, S_PWAIT, S_PSHIFT, S_RCMD, S_DGO, S_DUM, S_IGO, S_ID
  } seq_state_t;
endpackage

// File: rtl/p9_shifter.sv
module p9_shifter #(
  parameter int DIV = 100
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [p9_pkg::WORD_W-1:0] word,
  input  logic [3:0]              nbits,
  input  logic                    sdi,
  output logic                    busy,
  output logic                    done,
  output logic                    sclk,
  output logic                    sdo,
  output logic [p9_pkg::BYTE_W-1:0] rx
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int WW = p9_pkg::WORD_W;

  logic          active;
  logic          high_ph;
  logic [CW-1:0] cnt;
  logic [3:0]    bits_left;
  logic [WW-1:0] sh;
  logic [WW-1:0] rx_sh;
  logic          sclk_q, done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; high_ph <= 1'b0; cnt <= '0; bits_left <= '0;
      sh <= '0; rx_sh <= '0; sclk_q <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        active    <= 1'b1;
        high_ph   <= 1'b0;
        cnt       <= '0;
        bits_left <= nbits;
        sh        <= word;
        rx_sh     <= '0;
        sclk_q    <= 1'b0;
      end else if (active) begin
        if (cnt == CW'(DIV - 1)) begin
          cnt <= '0;
          if (!high_ph) begin
            sclk_q  <= 1'b1;
            high_ph <= 1'b1;
            rx_sh   <= {rx_sh[WW-2:0], sdi};
          end else begin
            sclk_q    <= 1'b0;
            high_ph   <= 1'b0;
            sh        <= {sh[WW-2:0], 1'b0};
            bits_left <= bits_left - 4'd1;
            if (bits_left == 4'd1) begin
              active <= 1'b0;
              done_q <= 1'b1;
            end
          end
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  assign busy = active;
  assign done = done_q;
  assign sclk = sclk_q;
  assign sdo  = active ? sh[WW-1] : 1'b0;
  assign rx   = rx_sh[p9_pkg::BYTE_W-1:0];

  a_r4_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> !sclk_q);
  a_r4_sdo_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_q |-> $stable(sdo));
  a_r1_bit_budget: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (bits_left != 4'd0 && bits_left <= 4'd9));
endmodule

// File: rtl/p9_sequencer.sv
module p9_sequencer #(
  parameter int PCW = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_req,
  input  logic                      rd_req,
  input  logic [p9_pkg::BYTE_W-1:0] cmd_byte,
  input  logic [PCW-1:0]            param_cnt,
  input  logic                      prm_valid,
  input  logic [p9_pkg::BYTE_W-1:0] prm_data,
  input  logic                      sh_busy,
  input  logic                      sh_done,
  input  logic [p9_pkg::BYTE_W-1:0] sh_rx,
  output logic                      req_ready,
  output logic                      busy,
  output logic                      done,
  output logic                      prm_ready,
  output logic [p9_pkg::BYTE_W-1:0] id_byte,
  output logic                      cs_n,
  output logic                      sh_start,
  output logic [p9_pkg::WORD_W-1:0] sh_word,
  output logic [3:0]                sh_nbits
);
  import p9_pkg::*;

  seq_state_t     state;
  logic [PCW-1:0] remain;
  logic           cs_n_q, done_q;
  logic [BYTE_W-1:0] id_q;
  logic           fire;

  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign prm_ready = (state == S_PWAIT) && !sh_busy;
  assign fire      = prm_valid && prm_ready;

  always_comb begin
    sh_start = 1'b0;
    sh_word  = '0;
    sh_nbits = 4'd9;
    unique case (state)
      S_IDLE: begin
        if (wr_req) begin
          sh_start = 1'b1; sh_word = {1'b0, cmd_byte};
        end else if (rd_req) begin
          sh_start = 1'b1; sh_word = {1'b0, ID_CMD};
        end
      end
      S_PWAIT: if (fire) begin
        sh_start = 1'b1; sh_word = {1'b1, prm_data};
      end
      S_DGO: sh_start = 1'b1;
      S_IGO: begin sh_start = 1'b1; sh_nbits = 4'd8; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; remain <= '0; cs_n_q <= 1'b1; done_q <= 1'b0; id_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        S_IDLE: begin
          if (wr_req) begin
            cs_n_q <= 1'b0; remain <= param_cnt; state <= S_CMD;
          end else if (rd_req) begin
            cs_n_q <= 1'b0; state <= S_RCMD;
          end
        end
        S_CMD, S_PSHIFT: if (sh_done) begin
          if (remain == '0) begin
            cs_n_q <= 1'b1; done_q <= 1'b1; state <= S_IDLE;
          end else begin
            state <= S_PWAIT;
          end
        end
        S_PWAIT: if (fire) begin
          remain <= remain - PCW'(1);
          state  <= S_PSHIFT;
        end
        S_RCMD: if (sh_done) state <= S_DGO;
        S_DGO:  state <= S_DUM;
        S_DUM:  if (sh_done) state <= S_IGO;
        S_IGO:  state <= S_ID;
        S_ID: if (sh_done) begin
          id_q <= sh_rx; cs_n_q <= 1'b1; done_q <= 1'b1; state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign cs_n    = cs_n_q;
  assign done    = done_q;
  assign id_byte = id_q;

  a_r6_cs_covers_shift: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> !cs_n_q);
  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r7_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n_q);
  a_r8_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sh_start |-> !sh_busy);
  a_r3_pending_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PWAIT) |-> (remain != '0));
endmodule

// File: rtl/panel9_serial_master.sv
module panel9_serial_master #(
  parameter int DIV        = 100,
  parameter int MAX_PARAMS = 32,
  parameter int PCW        = $clog2(MAX_PARAMS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_req,
  input  logic           rd_req,
  input  logic [7:0]     cmd_byte,
  input  logic [PCW-1:0] param_cnt,
  output logic           req_ready,
  output logic           busy,
  output logic           done,
  input  logic           prm_valid,
  input  logic [7:0]     prm_data,
  output logic           prm_ready,
  output logic [7:0]     id_byte,
  output logic           cs_n,
  output logic           sclk,
  output logic           sdo,
  input  logic           sdi
);
  logic       sh_start, sh_busy, sh_done;
  logic [8:0] sh_word;
  logic [3:0] sh_nbits;
  logic [7:0] sh_rx;

  p9_sequencer #(.PCW(PCW)) u_seq (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
    .cmd_byte(cmd_byte), .param_cnt(param_cnt),
    .prm_valid(prm_valid), .prm_data(prm_data),
    .sh_busy(sh_busy), .sh_done(sh_done), .sh_rx(sh_rx),
    .req_ready(req_ready), .busy(busy), .done(done), .prm_ready(prm_ready),
    .id_byte(id_byte), .cs_n(cs_n),
    .sh_start(sh_start), .sh_word(sh_word), .sh_nbits(sh_nbits)
  );

  p9_shifter #(.DIV(DIV)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(sh_start), .word(sh_word),
    .nbits(sh_nbits), .sdi(sdi), .busy(sh_busy), .done(sh_done),
    .sclk(sclk), .sdo(sdo), .rx(sh_rx)
  );
endmodule

// File: tb/sim_panel9_serial_master.sv
module sim_panel9_serial_master;
  localparam int DIV = 2;
  localparam int PCW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_req = 0, rd_req = 0, prm_valid = 0, sdi = 1'b1;
  logic [7:0] cmd_byte = 0, prm_data = 0;
  logic [PCW-1:0] param_cnt = 0;
  logic req_ready, busy, done, prm_ready, cs_n, sclk, sdo;
  logic [7:0] id_byte;

  always #2.5 clk = ~clk;

  panel9_serial_master #(.DIV(DIV), .MAX_PARAMS(32)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .rd_req(rd_req),
    .cmd_byte(cmd_byte), .param_cnt(param_cnt), .req_ready(req_ready),
    .busy(busy), .done(done), .prm_valid(prm_valid), .prm_data(prm_data),
    .prm_ready(prm_ready), .id_byte(id_byte), .cs_n(cs_n), .sclk(sclk),
    .sdo(sdo), .sdi(sdi)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // panel model
  logic [8:0] wlog [0:15];
  logic [8:0] cur = 0;
  int wcnt = 0, bitn = 0, frames = 0, frame_bits = 0;
  int last_rise = 0, prev_rise = 0;
  logic [7:0] id_val = 8'h00;

  function automatic logic drive(int k);
    if (k >= 18 && k < 26) return id_val[25-k];
    return 1'b1;
  endfunction

  always @(negedge cs_n) begin bitn = 0; wcnt = 0; sdi = drive(0); end
  always @(posedge sclk) if (!cs_n) begin
    cur = {cur[7:0], sdo};
    bitn++;
    if (bitn % 9 == 0 && wcnt < 16) begin wlog[wcnt] = cur; wcnt++; end
    prev_rise = last_rise; last_rise = cyc;
  end
  always @(negedge sclk) if (!cs_n) sdi = drive(bitn);
  always @(posedge cs_n) begin frames++; frame_bits = bitn; end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // {stall, cmd, n, p0, p1, p2, p3}
  localparam logic [43:0] VEC [5] = '{
    {1'b0, 8'h36, 3'd1, 8'h08, 8'h00, 8'h00, 8'h00},
    {1'b1, 8'hB6, 3'd4, 8'h22, 8'hE2, 8'hFF, 8'h04},
    {1'b0, 8'h29, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00},
    {1'b1, 8'hFF, 3'd3, 8'h98, 8'h00, 8'h06, 8'h00},
    {1'b0, 8'h00, 3'd2, 8'hA5, 8'h5A, 8'h00, 8'h00}
  };

  task automatic wait_done(output int pulses_after);
    while (done !== 1'b1) @(negedge clk);
    @(negedge clk);
    pulses_after = (done === 1'b1) ? 1 : 0;
  endtask

  task automatic run_write(input logic [43:0] v);
    logic [7:0] cmd; int n; logic stall; int idx; bit last_fire; int extra;
    stall = v[43]; cmd = v[42:35]; n = int'(v[34:32]);
    @(negedge clk);
    wr_req = 1; cmd_byte = cmd; param_cnt = PCW'(n);
    @(negedge clk);
    wr_req = 0;
    idx = 0; last_fire = 0;
    while (done !== 1'b1) begin
      if (last_fire) idx++;
      prm_valid = (idx < n) && !(stall && (cyc % 3 == 0));
      prm_data  = (idx < n) ? v[31-8*idx -: 8] : 8'h00;
      #1 last_fire = prm_valid && prm_ready;
      check(!(prm_ready && busy && cs_n), "R8 ready while frame open", prm_ready, 0);
      @(negedge clk);
    end
    prm_valid = 0;
    check(cs_n === 1'b1 && busy === 1'b0, "R6 cs/busy at done", {cs_n, busy}, 2'b10);
    @(negedge clk);
    check(done === 1'b0, "R6 done single cycle", done, 0);
    check(wcnt == n + 1, "R3 word count", wcnt, n + 1);
    check(frame_bits == 9 * (n + 1), "R1 frame bits", frame_bits, 9 * (n + 1));
    check(wlog[0] == {1'b0, cmd}, "R2 command word", wlog[0], {1'b0, cmd});
    for (int i = 0; i < n; i++)
      check(wlog[i+1] == {1'b1, v[31-8*i -: 8]}, "R3 parameter word", wlog[i+1], {1'b1, v[31-8*i -: 8]});
    check(n == 0 || last_rise - prev_rise == 2 * DIV, "R4 clock period", last_rise - prev_rise, 2 * DIV);
    check(sclk === 1'b0, "R4 sclk idle low", sclk, 0);
    extra = 0;
  endtask

  task automatic run_read(input logic [7:0] idv);
    int p;
    id_val = idv;
    @(negedge clk); rd_req = 1;
    @(negedge clk); rd_req = 0;
    wait_done(p);
    check(p == 0, "R6 done single cycle (read)", p, 0);
    check(id_byte == idv, "R5 identifier", id_byte, idv);
    check(wlog[0] == 9'h004, "R5 read command word", wlog[0], 9'h004);
    check(frame_bits == 26, "R5 read frame length", frame_bits, 26);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int f0; int p;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    frames = 0;
    check(cs_n === 1 && sclk === 0 && sdo === 0, "R9 reset pins", {cs_n, sclk, sdo}, 3'b100);
    check(busy === 0 && done === 0 && req_ready === 1, "R9 reset status", {busy, done, req_ready}, 3'b001);
    check(id_byte === 8'h00, "R9 reset id", id_byte, 0);

    for (int i = 0; i < 5; i++) run_write(VEC[i]);

    run_read(8'h80);
    run_read(8'h5A);
    run_read(8'h00);

    // R7: requests during busy are ignored
    f0 = frames;
    @(negedge clk); wr_req = 1; cmd_byte = 8'h11; param_cnt = 0;
    @(negedge clk); wr_req = 0;
    repeat (3) @(negedge clk);
    check(req_ready === 1'b0, "R7 not ready while busy", req_ready, 0);
    wr_req = 1; rd_req = 1; cmd_byte = 8'h77;
    @(negedge clk); wr_req = 0; rd_req = 0;
    wait_done(p);
    repeat (60) @(negedge clk);
    check(frames - f0 == 1, "R7 busy request ignored", frames - f0, 1);
    check(wlog[0] == 9'h011 && frame_bits == 9, "R7 frame unchanged", wlog[0], 9'h011);
    check(id_byte == 8'h00, "R5 id held", id_byte, 0);

    // R7: write wins over read
    @(negedge clk); wr_req = 1; rd_req = 1; cmd_byte = 8'h3A; param_cnt = 0;
    @(negedge clk); wr_req = 0; rd_req = 0;
    wait_done(p);
    check(wlog[0] == 9'h03A && frame_bits == 9, "R7 write priority", wlog[0], 9'h03A);

    // R8: stall long with valid low, nothing consumed, cs held
    @(negedge clk); wr_req = 1; cmd_byte = 8'hC5; param_cnt = 1;
    @(negedge clk); wr_req = 0;
    while (prm_ready !== 1'b1) @(negedge clk);
    repeat (20) @(negedge clk);
    check(cs_n === 1'b0 && busy === 1'b1 && wcnt == 1, "R8 stall holds frame", wcnt, 1);
    prm_valid = 1; prm_data = 8'h6A;
    @(negedge clk); prm_valid = 0;
    wait_done(p);
    check(wcnt == 2 && wlog[1] == 9'h16A, "R8 byte taken on handshake", wlog[1], 9'h16A);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule